// File: doc/BRIEF.md
# Iterative Half-Adder Recursive Adder

This block adds two unsigned operands using only a row of half adders. On the first pass each bit position produces a partial sum and a partial carry from its operand bits. On every later pass each bit takes its own previous sum and the carry handed up by the bit below. The row keeps repeating this until no carry remains anywhere. Bits whose carries are absorbed at once settle in parallel, so on random operands the number of passes grows roughly with the logarithm of the width instead of with the width itself.

The design is a clocked emulation of a self-timed scheme and runs one pass per clock. A request input selects what enters the half adders. While request is low, the block takes in fresh operands on every clock. Once request is raised it iterates, and a completion detector raises a done flag after the carry row has drained. The result then holds until request is dropped, which puts the block back into operand-load mode.

Top module: `iter_ha_adder`

## Requirements
- R1: While `req` is low, every clock loads `sum` with `op_a XOR op_b` and the internal carries with `op_a AND op_b`, and clears `cout` and `done`.
- R2: While `req` is high, every clock updates bit i as new sum = old sum XOR carry-in and new carry = old sum AND carry-in. The carry-in of bit i is the stored carry of bit i-1, and the carry-in of bit 0 is always zero. A bit therefore never holds sum 1 and carry 1 at the same time.
- R3: The carry produced by the top bit is absorbed into a sticky `cout` register. Once `cout` is set it stays 1 until `req` falls.
- R4: When `done` is high, `{cout, sum}` equals `op_a + op_b` for the operands loaded while `req` was low.
- R5: `done` rises exactly one clock after the internal carry row is all zeros with `req` high. It falls one clock after `req` goes low. For operands that produce no carries, `done` is high after the first clock with `req` high.
- R6: `done` is reached no later than WIDTH+1 clocks after the first clock with `req` high. Adding all-ones and 1 takes exactly WIDTH+1 clocks.
- R7: While `req` stays high after completion, `sum`, `cout` and `done` hold their values and changes on `op_a` and `op_b` have no effect.
- R8: During reset `sum`, `cout` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one iteration per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request and mux select: 0 loads operands, 1 iterates |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH | Running sum, final when `done` is high |
| cout | output | 1 | Sticky carry out of the top bit |
| done | output | 1 | Completion flag, carry row drained |

## Verification
The assertions assume that `req` makes a single rise for each addition. They also assume that the operands stay steady on the clock before that rise, so that the value loaded is the one being added, and that `req` is only dropped after `done` or while still in load mode. Under these assumptions the assertions can treat sum plus twice the carries plus the weight of `cout` as a conserved total during iteration. The bench holds `req` low for a full clock after presenting each operand pair, and it keeps `req` high until `done` is seen. Operand changes are made only during the hold phase, where the requirements say they must be ignored. A sweep of every operand pair on a 4-bit instance covers every carry-ripple length, including the longest one.

// File: rtl/iha_pkg.sv
package iha_pkg;

   typedef struct packed {
      logic c;
      logic s;
   } iha_pair_t;

   function automatic iha_pair_t iha_half_add(input logic x, input logic y);
      iha_pair_t r;
      r.s = x ^ y;
      r.c = x & y;
      return r;
   endfunction

endpackage

// File: rtl/iha_cell.sv
module iha_cell
   import iha_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic opa,
   input  logic opb,
   input  logic cin,
   output logic s_q,
   output logic c_q
);

   logic      x_in;
   logic      y_in;
   iha_pair_t hp;

   // Select 0 routes the operand bits; select 1 routes the feedback paths.
   always_comb begin
      x_in = sel ? s_q : opa;
      y_in = sel ? cin : opb;
      hp   = iha_half_add(x_in, y_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= 1'b0;
         c_q <= 1'b0;
      end else begin
         s_q <= hp.s;
         c_q <= hp.c;
      end
   end

endmodule

// File: rtl/iha_done.sv
module iha_done #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [WIDTH-1:0] carry,
   output logic             done
);

   logic any_carry;

   assign any_carry = |carry;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= req & ~any_carry;
   end

endmodule

// File: rtl/iter_ha_adder.sv
module iter_ha_adder #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             done
);

   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("iter_ha_adder: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] carry_q;   // carry_q[i] is the carry leaving bit i
   logic [WIDTH-1:0] cin_vec;   // carry entering each bit
   logic             cout_q;

   assign cin_vec = {carry_q[TOP-1:0], 1'b0};

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      iha_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .sel   (req),
         .opa   (op_a[i]),
         .opb   (op_b[i]),
         .cin   (cin_vec[i]),
         .s_q   (sum[i]),
         .c_q   (carry_q[i])
      );
   end

   // Sticky carry-out: absorbs the top carry on each iteration.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cout_q <= 1'b0;
      else if (!req)           cout_q <= 1'b0;
      else if (carry_q[TOP])   cout_q <= 1'b1;
   end

   assign cout = cout_q;

   iha_done #(.WIDTH(WIDTH)) u_done (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .carry (carry_q),
      .done  (done)
   );

endmodule

// File: rtl/iha_checker.sv
module iha_checker #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [WIDTH-1:0] sum,
   input logic             cout,
   input logic             done,
   input logic [WIDTH-1:0] carry
);

   localparam int CW = $clog2(WIDTH + 4) + 1;

   logic [WIDTH+1:0] total;
   logic [CW-1:0]    iter_cnt;

   assign total = {1'b0, cout, sum} + {1'b0, carry, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    iter_cnt <= '0;
      else if (!req)                 iter_cnt <= '0;
      else if (!done && !(&iter_cnt)) iter_cnt <= iter_cnt + 1'b1;
   end

   AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (sum == $past(op_a ^ op_b)) && !done && !cout);            // R1

   AST_NO_BOTH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (sum & carry) == '0);                                               // R2

   AST_VALUE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req && $past(req)) |-> total == $past(total));                     // R4

   AST_COUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (req && cout) |=> cout);                                            // R3

   AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (req && carry == '0) |=> done);                                     // R5

   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req) && ($past(carry) == '0));                       // R5

   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      iter_cnt <= CW'(WIDTH + 1));                                        // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req && carry == '0) |=> $stable(sum) && $stable(cout));            // R7

   always_comb begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (sum == '0 && !cout && !done);           // R8
      end
   end

endmodule

bind iter_ha_adder iha_checker #(.WIDTH(WIDTH)) u_iha_checker (
   .clk   (clk),
   .rst_n (rst_n),
   .req   (req),
   .op_a  (op_a),
   .op_b  (op_b),
   .sum   (sum),
   .cout  (cout),
   .done  (done),
   .carry (carry_q)
);

// File: tb/tb_iter_ha_adder.sv
`timescale 1ns/1ps
module tb_iter_ha_adder;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic [W-1:0] sum;
   logic         cout;
   logic         done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   iter_ha_adder #(.WIDTH(W)) dut (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .op_a  (op_a),
      .op_b  (op_b),
      .sum   (sum),
      .cout  (cout),
      .done  (done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // Load operands, iterate, return clocks from the request rise to done.
   task automatic run_add(input int a, input int b, output int n);
      req  = 1'b0;
      op_a = W'(a);
      op_b = W'(b);
      @(negedge clk);
      chk("R1 load sum", int'(sum), (a ^ b) & ((1 << W) - 1));
      chk("R1 load flags", int'({cout, done}), 0);
      req = 1'b1;
      n = 0;
      while (!done && n < 3 * W) begin
         @(negedge clk);
         n++;
      end
      chk("R2 R4 sum", int'(sum), (a + b) & ((1 << W) - 1));
      chk("R3 R4 cout", int'(cout), (a + b) >> W);
      chk("R6 bound", int'(n <= W + 1), 1);
   endtask

   initial begin
      int n;
      #1;
      chk("R8 reset sum", int'(sum), 0);
      chk("R8 reset flags", int'({cout, done}), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: no carries at all, done after one clock
      run_add(0, 0, n);
      chk("R5 no-carry latency", n, 1);
      run_add(5, 10, n);
      chk("R5 disjoint latency", n, 1);

      // R6: longest ripple
      run_add((1 << W) - 1, 1, n);
      chk("R6 worst latency", n, W + 1);

      // R3: top carry only
      run_add(1 << (W - 1), 1 << (W - 1), n);
      chk("R3 top carry", int'({cout, sum}), 1 << W);

      // R7: operands ignored while request stays high
      run_add(7, 6, n);
      op_a = 4'hF;
      op_b = 4'h9;
      repeat (3) @(negedge clk);
      chk("R7 hold sum", int'(sum), 13);
      chk("R7 hold cout", int'(cout), 0);
      chk("R7 hold done", int'(done), 1);
      req = 1'b0;
      @(negedge clk);
      chk("R5 done falls", int'(done), 0);
      chk("R1 reload sum", int'(sum), 4'hF ^ 4'h9);

      // Exhaustive sweep of every operand pair
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            run_add(a, b, n);
         end
      end

      req = 1'b0;
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule